// File: doc/BRIEF.md
# DMA Channel Programmable Register Set

This block is the software-visible register bank of a single DMA channel. Software sees four 16-bit registers at byte offsets 0, 2, 4 and 6:

- a word counter, loaded with the negated transfer count;
- a word-address register;
- a control/status word;
- a data buffer pair at the last offset. Reads there return the input buffer, and writes there go to the output buffer.

Reads are combinational from the selected register. Writes take effect at the clock edge. The word counter and the address register change only on full-word writes. The control/status word and the output buffer accept byte-lane writes.

A separate cycle sequencer drives the peripheral side. It sends a pulse at the end of each transfer and a pulse when a transfer hits nonexistent memory. It can also load a word read from memory into the output buffer. The peripheral supplies the following, and the block latches the input data on a cycle request:

- a cycle request;
- input data;
- three status lines;
- an attention line;
- one increment enable for the word counter and one for the address counter.

The block drives these back to the peripheral:

- the READY and CYCLE flags;
- three function outputs;
- an initialise output;
- the output buffer;
- the 17-bit word address of the next transfer.

Top module: `dma_regs`

## Requirements
- R1: A synchronous active-low reset sets the word counter, the address register, the function bits, the extended address bits, the interrupt enable, CYCLE, the maintenance bit, the nonexistent-memory flag and both data buffers to zero, and sets READY. After reset, with the status and attention inputs low, the control/status word reads 0x0080.
- R2: A full-word write at offset 0 loads the word counter. The counter reads back at offset 0. Each end-of-transfer pulse adds one to it. When an increment takes it from 0xFFFF to 0x0000, READY is set at that edge.
- R3: A full-word write at offset 2 loads bits 15:1 of the address register, and bit 0 reads as 0. Each end-of-transfer pulse advances the register by one word. A carry out of bit 15 increments the control/status bits 5:4, which wrap from 3 to 0. The output `xfer_waddr` is {bits 5:4, address bits 15:1}.
- R4: While `wc_step_en` is low, an end-of-transfer pulse leaves the word counter unchanged. While `addr_step_en` is low, the pulse leaves the address register and the extended bits unchanged. Each enable is independent of the other.
- R5: A write at offset 0 or 2 that does not enable both byte lanes leaves that register unchanged.
- R6: Control/status layout:
  - bit 0 is the start command and always reads 0;
  - bits 3:1 are the function bits;
  - bits 5:4 are the extended address bits;
  - bit 6 is the interrupt enable;
  - bit 7 is READY;
  - bit 8 is CYCLE;
  - bits 11:9 follow `dev_status` live;
  - bit 12 is the maintenance bit;
  - bit 13 follows `dev_attn` live;
  - bit 14 is the nonexistent-memory flag;
  - bit 15 is the OR of bits 14 and 13.

  Writes have no effect on bits 7, 9–11, 13 and 15.
- R7: A control/status write with only lane 0 enabled (`wr_be`=01) changes only bits 7:0. A write with only lane 1 enabled (`wr_be`=10) changes only bits 15:8.
- R8: A lane-0 control/status write with bit 0 set clears READY at that edge. READY is set one edge after ERROR (bit 15) is seen high. A set condition overrides a clear in the same cycle.
- R9: A cycle request sets CYCLE. An end-of-transfer pulse clears it. A lane-1 write loads it from bit 8. The priority order is request, then end-of-transfer, then the write.
- R10: A `nxm_pulse` sets bit 14. Writing 0 to bit 14 clears it. Writing 1 to bit 14 has no effect. While bit 14 is set, end-of-transfer pulses change neither counter.
- R11: `fn_out` mirrors control/status bits 3:1. `dev_init` is high while reset is asserted or while bit 2 is 1.
- R12: A cycle request latches `dev_din` into the input buffer, which reads at offset 6. Writes at offset 6 fill the output buffer per byte lane, and the buffer drives `dev_dout`. `mem_load` loads `mem_rdata` into the output buffer and wins over a software write in the same cycle.
- R13: A software write to the word counter, the address register or the extended bits wins over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_sel | input | 2 | Register select: byte offset divided by 2 |
| wr_en | input | 1 | Write strobe |
| wr_be | input | 2 | Byte-lane enables, bit 0 = low byte |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data of the selected register |
| dev_din | input | 16 | Peripheral input data |
| dev_dout | output | 16 | Output buffer to the peripheral |
| cyc_req | input | 1 | Cycle request pulse |
| wc_step_en | input | 1 | Word counter increment enable |
| addr_step_en | input | 1 | Address increment enable |
| dev_status | input | 3 | Peripheral status lines |
| dev_attn | input | 1 | Peripheral attention line |
| xfer_done | input | 1 | End-of-transfer pulse from the sequencer |
| nxm_pulse | input | 1 | Nonexistent-memory error pulse |
| mem_load | input | 1 | Load the output buffer from memory data |
| mem_rdata | input | 16 | Memory data for the output buffer |
| fn_out | output | 3 | Function outputs, control/status bits 3:1 |
| dev_init | output | 1 | Initialise output to the peripheral |
| ready | output | 1 | READY flag |
| cycle_flag | output | 1 | CYCLE flag |
| xfer_waddr | output | 17 | Word address of the next transfer |

## Verification
The hardest state to reach is the carry from the address register into the extended bits. Normal traffic would need tens of thousands of transfers to get there. The stimulus instead loads the address register with its last word and sets the extended bits directly. One end-of-transfer pulse then shows both the carry and the wrap from 3 to 0. Same-edge collisions also need deliberate stimulus, because they cannot occur through ordinary sequencing:

- a counter write together with an increment;
- a memory load together with a buffer write;
- an error arriving together with a start command.

The bench drives each of these on a single edge and compares against a behavioural model on every clock.

// File: rtl/dmareg_pkg.sv
// Package: shared register selects and control/status bit positions.
// Assumes a 16-bit register word; positions are fixed by the layout.
package dmareg_pkg;
    typedef enum logic [1:0] {
        SEL_WC  = 2'd0,
        SEL_BA  = 2'd1,
        SEL_CSR = 2'd2,
        SEL_BUF = 2'd3
    } reg_sel_e;

    localparam int CSR_GO    = 0;
    localparam int CSR_FN_LO = 1;
    localparam int CSR_XA_LO = 4;
    localparam int CSR_IE    = 6;
    localparam int CSR_RDY   = 7;
    localparam int CSR_CYC   = 8;
    localparam int CSR_ST_LO = 9;
    localparam int CSR_MNT   = 12;
    localparam int CSR_ATN   = 13;
    localparam int CSR_NXM   = 14;
    localparam int CSR_ERR   = 15;
endpackage

// File: rtl/dma_wc_counter.sv
// Word counter: loadable up-counter, holds the negated transfer count.
// Assumes load and step may coincide; load wins. wrap flags the step
// that moves the count from all ones to zero.
module dma_wc_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic [W-1:0] count,
    output logic         wrap
);
    logic [W-1:0] cnt_q;

    // Count register: reset, software load, or one increment.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (load)  cnt_q <= load_val;
        else if (step)  cnt_q <= cnt_q + 1'b1;
    end

    assign count = cnt_q;
    assign wrap  = step & ~load & (&cnt_q);
endmodule

// File: rtl/dma_addr_counter.sv
// Address counter: word address low part plus extended high bits.
// Assumes low and high parts are loaded by separate writes; a load of
// either part wins over the increment of that part.
module dma_addr_counter #(
    parameter int LO_W = 15,
    parameter int HI_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_lo,
    input  logic [LO_W-1:0] lo_val,
    input  logic            load_hi,
    input  logic [HI_W-1:0] hi_val,
    input  logic            step,
    output logic [LO_W-1:0] lo,
    output logic [HI_W-1:0] hi
);
    logic [LO_W-1:0] lo_q;
    logic [HI_W-1:0] hi_q;
    logic            carry;

    assign carry = step & ~load_lo & (&lo_q);

    // Low part: reset, software load, or advance one word.
    always_ff @(posedge clk) begin
        if (!rst_n)        lo_q <= '0;
        else if (load_lo)  lo_q <= lo_val;
        else if (step)     lo_q <= lo_q + 1'b1;
    end

    // High part: reset, software load, or take the carry (wraps).
    always_ff @(posedge clk) begin
        if (!rst_n)        hi_q <= '0;
        else if (load_hi)  hi_q <= hi_val;
        else if (carry)    hi_q <= hi_q + 1'b1;
    end

    assign lo = lo_q;
    assign hi = hi_q;
endmodule

// File: rtl/dma_csr_ctrl.sv
// Control/status word: function, enable and maintenance bits, the READY,
// CYCLE and nonexistent-memory flags, and the assembled read word.
// Assumes byte-lane write strobes are already decoded for this register.
module dma_csr_ctrl #(
    parameter int DW   = 16,
    parameter int FN_W = 3,
    parameter int XA_W = 2,
    parameter int ST_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_lo,
    input  logic            wr_hi,
    input  logic [DW-1:0]   wr_data,
    input  logic [XA_W-1:0] xa,
    input  logic [ST_W-1:0] dev_status,
    input  logic            dev_attn,
    input  logic            xfer_done,
    input  logic            cyc_req,
    input  logic            nxm_pulse,
    input  logic            wc_wrap,
    output logic [FN_W-1:0] fn,
    output logic            ready,
    output logic            cycle,
    output logic            nxm,
    output logic            xfer_ok,
    output logic [DW-1:0]   csr_word
);
    import dmareg_pkg::*;

    logic [FN_W-1:0] fn_q;
    logic            ie_q, ready_q, cycle_q, maint_q, nxm_q;
    logic            err, go;
    logic            unused_csr_bits;

    assign err     = nxm_q | dev_attn;
    assign go      = wr_lo & wr_data[CSR_GO];
    assign xfer_ok = xfer_done & ~nxm_q;
    assign unused_csr_bits = ^{wr_data[DW-1:CSR_NXM+1], wr_data[CSR_ATN],
                               wr_data[CSR_MNT-1:CSR_CYC+1], wr_data[CSR_RDY],
                               wr_data[CSR_XA_LO +: XA_W]};

    // Low-byte read/write fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fn_q <= '0;
            ie_q <= 1'b0;
        end else if (wr_lo) begin
            fn_q <= wr_data[CSR_FN_LO +: FN_W];
            ie_q <= wr_data[CSR_IE];
        end
    end

    // Maintenance bit, high byte.
    always_ff @(posedge clk) begin
        if (!rst_n)      maint_q <= 1'b0;
        else if (wr_hi)  maint_q <= wr_data[CSR_MNT];
    end

    // Nonexistent-memory flag: pulse sets, writing zero clears.
    always_ff @(posedge clk) begin
        if (!rst_n)                              nxm_q <= 1'b0;
        else if (nxm_pulse)                      nxm_q <= 1'b1;
        else if (wr_hi && !wr_data[CSR_NXM])     nxm_q <= 1'b0;
    end

    // CYCLE: request sets, end of transfer clears, else software.
    always_ff @(posedge clk) begin
        if (!rst_n)          cycle_q <= 1'b0;
        else if (cyc_req)    cycle_q <= 1'b1;
        else if (xfer_done)  cycle_q <= 1'b0;
        else if (wr_hi)      cycle_q <= wr_data[CSR_CYC];
    end

    // READY: completion or error sets it, the start command clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)               ready_q <= 1'b1;
        else if (err || wc_wrap)  ready_q <= 1'b1;
        else if (go)              ready_q <= 1'b0;
    end

    // Read word assembly; bit 0 always reads zero.
    always_comb begin
        csr_word                        = '0;
        csr_word[CSR_FN_LO +: FN_W]     = fn_q;
        csr_word[CSR_XA_LO +: XA_W]     = xa;
        csr_word[CSR_IE]                = ie_q;
        csr_word[CSR_RDY]               = ready_q;
        csr_word[CSR_CYC]               = cycle_q;
        csr_word[CSR_ST_LO +: ST_W]     = dev_status;
        csr_word[CSR_MNT]               = maint_q;
        csr_word[CSR_ATN]               = dev_attn;
        csr_word[CSR_NXM]               = nxm_q;
        csr_word[CSR_ERR]               = err;
    end

    assign fn    = fn_q;
    assign ready = ready_q;
    assign cycle = cycle_q;
    assign nxm   = nxm_q;
endmodule

// File: rtl/dma_regs.sv
// DMA channel register set: decodes programmed accesses, holds the data
// buffers, and wires the counters and control/status logic together.
// Assumes one access per cycle; reads are combinational.
module dma_regs #(
    parameter int DATA_W = 16,
    parameter int XA_W   = 2,
    parameter int FN_W   = 3,
    parameter int ST_W   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               reg_sel,
    input  logic                     wr_en,
    input  logic [DATA_W/8-1:0]      wr_be,
    input  logic [DATA_W-1:0]        wr_data,
    output logic [DATA_W-1:0]        rd_data,
    input  logic [DATA_W-1:0]        dev_din,
    output logic [DATA_W-1:0]        dev_dout,
    input  logic                     cyc_req,
    input  logic                     wc_step_en,
    input  logic                     addr_step_en,
    input  logic [ST_W-1:0]          dev_status,
    input  logic                     dev_attn,
    input  logic                     xfer_done,
    input  logic                     nxm_pulse,
    input  logic                     mem_load,
    input  logic [DATA_W-1:0]        mem_rdata,
    output logic [FN_W-1:0]          fn_out,
    output logic                     dev_init,
    output logic                     ready,
    output logic                     cycle_flag,
    output logic [DATA_W-2+XA_W:0]   xfer_waddr
);
    import dmareg_pkg::*;

    localparam int NB   = DATA_W / 8;
    localparam int LO_W = DATA_W - 1;

    logic              wr_full, wr_wc, wr_ba, csr_lo, csr_hi, buf_sel;
    logic [DATA_W-1:0] wc_q, csr_word, in_buf_q, out_buf_q;
    logic [LO_W-1:0]   ba_lo;
    logic [XA_W-1:0]   xa;
    logic              wc_wrap, xfer_ok, nxm_flag;
    logic              unused_ba_bit;

    assign wr_full = wr_en & (&wr_be);
    assign wr_wc   = wr_full & (reg_sel == SEL_WC);
    assign wr_ba   = wr_full & (reg_sel == SEL_BA);
    assign csr_lo  = wr_en & (reg_sel == SEL_CSR) & wr_be[0];
    assign csr_hi  = wr_en & (reg_sel == SEL_CSR) & wr_be[NB-1];
    assign buf_sel = wr_en & (reg_sel == SEL_BUF);
    assign unused_ba_bit = wr_data[0];

    dma_wc_counter #(.W(DATA_W)) u_wc (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_wc),
        .load_val (wr_data),
        .step     (xfer_ok & wc_step_en),
        .count    (wc_q),
        .wrap     (wc_wrap)
    );

    dma_addr_counter #(.LO_W(LO_W), .HI_W(XA_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_lo (wr_ba),
        .lo_val  (wr_data[DATA_W-1:1]),
        .load_hi (csr_lo),
        .hi_val  (wr_data[CSR_XA_LO +: XA_W]),
        .step    (xfer_ok & addr_step_en),
        .lo      (ba_lo),
        .hi      (xa)
    );

    dma_csr_ctrl #(.DW(DATA_W), .FN_W(FN_W), .XA_W(XA_W), .ST_W(ST_W)) u_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_lo      (csr_lo),
        .wr_hi      (csr_hi),
        .wr_data    (wr_data),
        .xa         (xa),
        .dev_status (dev_status),
        .dev_attn   (dev_attn),
        .xfer_done  (xfer_done),
        .cyc_req    (cyc_req),
        .nxm_pulse  (nxm_pulse),
        .wc_wrap    (wc_wrap),
        .fn         (fn_out),
        .ready      (ready),
        .cycle      (cycle_flag),
        .nxm        (nxm_flag),
        .xfer_ok    (xfer_ok),
        .csr_word   (csr_word)
    );

    // Input buffer: captures peripheral data on a cycle request.
    always_ff @(posedge clk) begin
        if (!rst_n)        in_buf_q <= '0;
        else if (cyc_req)  in_buf_q <= dev_din;
    end

    // Output buffer, one register per byte lane.
    for (genvar g = 0; g < NB; g++) begin : g_out_lane
        // Memory load wins; otherwise a lane-enabled software write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                out_buf_q[g*8 +: 8] <= '0;
            else if (mem_load)
                out_buf_q[g*8 +: 8] <= mem_rdata[g*8 +: 8];
            else if (buf_sel && wr_be[g])
                out_buf_q[g*8 +: 8] <= wr_data[g*8 +: 8];
        end
    end

    // Read multiplexer.
    always_comb begin
        case (reg_sel)
            SEL_WC:  rd_data = wc_q;
            SEL_BA:  rd_data = {ba_lo, 1'b0};
            SEL_CSR: rd_data = csr_word;
            default: rd_data = in_buf_q;
        endcase
    end

    assign dev_dout   = out_buf_q;
    assign xfer_waddr = {xa, ba_lo};
    assign dev_init   = ~rst_n | fn_out[1];
endmodule

// File: rtl/dma_regs_chk.sv
// Checker for dma_regs: temporal properties on ports and counter state.
// Assumes it is attached with the bind statement at the end of this file.
module dma_regs_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    reg_sel,
    input logic          wr_en,
    input logic [1:0]    wr_be,
    input logic [DW-1:0] wr_data,
    input logic          cyc_req,
    input logic          wc_step_en,
    input logic          dev_attn,
    input logic          xfer_done,
    input logic          nxm_pulse,
    input logic          ready,
    input logic          cycle_flag,
    input logic          dev_init,
    input logic [DW-1:0] wc_q,
    input logic          nxm_flag
);
    logic wc_write;
    assign wc_write = wr_en && reg_sel == 2'd0 && wr_be == 2'b11;

    assert_cycle_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_req |=> cycle_flag);

    assert_error_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (nxm_flag || dev_attn) |=> ready);

    assert_go_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == 2'd2 && wr_be[0] && wr_data[0] && !nxm_flag && !dev_attn
         && !(xfer_done && wc_step_en && (&wc_q))) |=> !ready);

    assert_byte_wc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == 2'd0 && wr_be != 2'b11 && !xfer_done) |=> $stable(wc_q));

    assert_nxm_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        nxm_pulse |=> nxm_flag);

    assert_nxm_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (nxm_flag && xfer_done && !wc_write) |=> $stable(wc_q));

    // R11: initialise output held during reset.
    always_comb begin
        if (!rst_n) assert_init_reset_R11: assert (dev_init);
    end
endmodule

bind dma_regs dma_regs_chk #(.DW(16)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_sel    (reg_sel),
    .wr_en      (wr_en),
    .wr_be      (wr_be),
    .wr_data    (wr_data),
    .cyc_req    (cyc_req),
    .wc_step_en (wc_step_en),
    .dev_attn   (dev_attn),
    .xfer_done  (xfer_done),
    .nxm_pulse  (nxm_pulse),
    .ready      (ready),
    .cycle_flag (cycle_flag),
    .dev_init   (dev_init),
    .wc_q       (wc_q),
    .nxm_flag   (nxm_flag)
);

// File: tb/test_dma_regs.sv
module test_dma_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_be = 2'b00;
    logic [15:0] wr_data = 16'h0;
    logic [15:0] rd_data;
    logic [15:0] dev_din = 16'h0;
    logic [15:0] dev_dout;
    logic        cyc_req = 1'b0;
    logic        wc_step_en = 1'b1;
    logic        addr_step_en = 1'b1;
    logic [2:0]  dev_status = 3'b000;
    logic        dev_attn = 1'b0;
    logic        xfer_done = 1'b0;
    logic        nxm_pulse = 1'b0;
    logic        mem_load = 1'b0;
    logic [15:0] mem_rdata = 16'h0;
    logic [2:0]  fn_out;
    logic        dev_init;
    logic        ready;
    logic        cycle_flag;
    logic [16:0] xfer_waddr;

    always #10 clk = ~clk;

    dma_regs i_dma_regs (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .wr_be(wr_be),
        .wr_data(wr_data), .rd_data(rd_data), .dev_din(dev_din), .dev_dout(dev_dout),
        .cyc_req(cyc_req), .wc_step_en(wc_step_en), .addr_step_en(addr_step_en),
        .dev_status(dev_status), .dev_attn(dev_attn), .xfer_done(xfer_done),
        .nxm_pulse(nxm_pulse), .mem_load(mem_load), .mem_rdata(mem_rdata),
        .fn_out(fn_out), .dev_init(dev_init), .ready(ready), .cycle_flag(cycle_flag),
        .xfer_waddr(xfer_waddr)
    );

    int checks = 0;
    int failures = 0;
    bit cmp_on = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model state.
    logic [15:0] m_wc = 0, m_inb = 0, m_outb = 0;
    logic [16:0] m_addr = 0;
    logic [2:0]  m_fn = 0;
    logic        m_ie = 0, m_rdy = 1, m_cyc = 0, m_mnt = 0, m_nxm = 0;

    function automatic logic [15:0] m_csr();
        return {m_nxm | dev_attn, m_nxm, dev_attn, m_mnt, dev_status, m_cyc, m_rdy,
                m_ie, m_addr[16:15], m_fn, 1'b0};
    endfunction

    function automatic logic [15:0] m_read(input logic [1:0] s);
        case (s)
            2'd0: return m_wc;
            2'd1: return {m_addr[14:0], 1'b0};
            2'd2: return m_csr();
            default: return m_inb;
        endcase
    endfunction

    // Model update on every clock edge.
    always @(posedge clk) begin
        logic err, ok, full, wrapped, go;
        if (!rst_n) begin
            m_wc = 0; m_addr = 0; m_fn = 0; m_ie = 0; m_rdy = 1; m_cyc = 0;
            m_mnt = 0; m_nxm = 0; m_inb = 0; m_outb = 0;
        end else begin
            err = m_nxm | dev_attn;
            ok = xfer_done && !m_nxm;
            full = wr_en && wr_be == 2'b11;
            wrapped = 0;
            go = 0;
            if (full && reg_sel == 2'd0) m_wc = wr_data;
            else if (ok && wc_step_en) begin
                m_wc = m_wc + 16'd1;
                wrapped = (m_wc == 16'd0);
            end
            if (full && reg_sel == 2'd1) m_addr[14:0] = wr_data[15:1];
            else if (ok && addr_step_en) m_addr = m_addr + 17'd1;
            if (wr_en && reg_sel == 2'd2 && wr_be[0]) begin
                m_fn = wr_data[3:1]; m_addr[16:15] = wr_data[5:4];
                m_ie = wr_data[6]; go = wr_data[0];
            end
            if (wr_en && reg_sel == 2'd2 && wr_be[1]) begin
                m_mnt = wr_data[12];
                if (!wr_data[14]) m_nxm = 0;
                m_cyc = wr_data[8];
            end
            if (xfer_done) m_cyc = 0;
            if (cyc_req) begin m_cyc = 1; m_inb = dev_din; end
            if (nxm_pulse) m_nxm = 1;
            if (err || wrapped) m_rdy = 1;
            else if (go) m_rdy = 0;
            if (mem_load) m_outb = mem_rdata;
            else if (wr_en && reg_sel == 2'd3) begin
                if (wr_be[0]) m_outb[7:0] = wr_data[7:0];
                if (wr_be[1]) m_outb[15:8] = wr_data[15:8];
            end
        end
    end

    task automatic compare_all();
        if (cmp_on) begin
            chk("R12 dev_dout", dev_dout, m_outb);
            chk("R11 fn_out", fn_out, m_fn);
            chk("R11 dev_init", dev_init, !rst_n | m_fn[1]);
            chk("R8 ready", ready, m_rdy);
            chk("R9 cycle_flag", cycle_flag, m_cyc);
            chk("R3 xfer_waddr", xfer_waddr, m_addr);
            case (reg_sel)
                2'd0: chk("R2 rd_data word counter", rd_data, m_read(reg_sel));
                2'd1: chk("R3 rd_data address", rd_data, m_read(reg_sel));
                2'd2: chk("R6 rd_data control/status", rd_data, m_read(reg_sel));
                default: chk("R12 rd_data input buffer", rd_data, m_read(reg_sel));
            endcase
        end
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(input logic [1:0] s, input logic [1:0] be, input logic [15:0] d);
        reg_sel = s; wr_be = be; wr_data = d; wr_en = 1'b1;
        step();
        wr_en = 1'b0;
    endtask

    task automatic done(input logic wce, input logic bae);
        wc_step_en = wce; addr_step_en = bae; xfer_done = 1'b1;
        step();
        xfer_done = 1'b0; wc_step_en = 1'b1; addr_step_en = 1'b1;
    endtask

    task automatic rdchk(input logic [1:0] s, input logic [15:0] exp, input string tag);
        reg_sel = s;
        #1;
        chk(tag, rd_data, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 dev_init during reset", dev_init, 1'b1);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        step();
        // R1 reset values
        rdchk(2'd0, 16'h0000, "R1 word counter reset");
        rdchk(2'd1, 16'h0000, "R1 address reset");
        rdchk(2'd2, 16'h0080, "R1 control/status reset");
        chk("R1 ready reset", ready, 1'b1);
        // R2/R6/R8 program a three-word transfer
        wr(2'd0, 2'b11, 16'hFFFD);
        wr(2'd1, 2'b11, 16'h1234);
        rdchk(2'd1, 16'h1234, "R3 address readback");
        chk("R3 xfer_waddr", xfer_waddr, 17'h0091A);
        wr(2'd2, 2'b01, 16'h004B);
        rdchk(2'd2, 16'h004A, "R6 go reads zero");
        chk("R8 go clears ready", ready, 1'b0);
        chk("R11 fn_out", fn_out, 3'b101);
        // R9/R12 cycle request
        dev_din = 16'hBEEF; cyc_req = 1'b1; step(); cyc_req = 1'b0;
        rdchk(2'd3, 16'hBEEF, "R12 input buffer latched");
        chk("R9 cycle set", cycle_flag, 1'b1);
        done(1'b1, 1'b1);
        chk("R9 cycle cleared", cycle_flag, 1'b0);
        rdchk(2'd0, 16'hFFFE, "R2 count increment");
        done(1'b0, 1'b1);
        rdchk(2'd0, 16'hFFFE, "R4 word counter held");
        rdchk(2'd1, 16'h1238, "R4 address advances");
        done(1'b1, 1'b0);
        rdchk(2'd1, 16'h1238, "R4 address held");
        chk("R2 ready still low", ready, 1'b0);
        done(1'b1, 1'b1);
        rdchk(2'd0, 16'h0000, "R2 count reaches zero");
        chk("R2 ready on wrap", ready, 1'b1);
        // R13 write wins over increment
        reg_sel = 2'd0; wr_be = 2'b11; wr_data = 16'h0100; wr_en = 1'b1; xfer_done = 1'b1;
        step(); wr_en = 1'b0; xfer_done = 1'b0;
        rdchk(2'd0, 16'h0100, "R13 write over increment");
        rdchk(2'd1, 16'h123C, "R13 address still steps");
        // R5 partial writes ignored
        wr(2'd0, 2'b01, 16'h5555);
        rdchk(2'd0, 16'h0100, "R5 word counter byte write");
        wr(2'd1, 2'b10, 16'hAAAA);
        rdchk(2'd1, 16'h123C, "R5 address byte write");
        // R3 carry into extended bits and wrap
        wr(2'd2, 2'b01, 16'h0010);
        wr(2'd1, 2'b11, 16'hFFFE);
        done(1'b1, 1'b1);
        rdchk(2'd1, 16'h0000, "R3 address wraps low");
        rdchk(2'd2, 16'h00A0, "R3 extended bits carry");
        chk("R3 xfer_waddr carry", xfer_waddr, 17'h10000);
        wr(2'd2, 2'b01, 16'h0030);
        wr(2'd1, 2'b11, 16'hFFFE);
        done(1'b1, 1'b1);
        rdchk(2'd2, 16'h0080, "R3 extended bits wrap");
        // R7 byte lanes of control/status
        wr(2'd2, 2'b10, 16'hFFFF);
        rdchk(2'd2, 16'h1180, "R7 high lane only");
        wr(2'd2, 2'b01, 16'hFFFF);
        rdchk(2'd2, 16'h117E, "R7 low lane only");
        chk("R11 dev_init from function bit", dev_init, 1'b1);
        wr(2'd2, 2'b01, 16'h0000);
        chk("R11 dev_init released", dev_init, 1'b0);
        wr(2'd2, 2'b10, 16'h0000);
        rdchk(2'd2, 16'h0000, "R7 cleared");
        // R6 live status
        dev_status = 3'b101;
        rdchk(2'd2, 16'h0A00, "R6 status inputs");
        dev_status = 3'b000;
        // R8/R10 attention
        dev_attn = 1'b1; step();
        rdchk(2'd2, 16'hA080, "R10 attention error");
        dev_attn = 1'b0;
        wr(2'd2, 2'b01, 16'h0001);
        chk("R8 go after attention", ready, 1'b0);
        // R8 error overrides go in the same cycle
        dev_attn = 1'b1; wr(2'd2, 2'b01, 16'h0001); dev_attn = 1'b0;
        chk("R8 set wins over go", ready, 1'b1);
        wr(2'd2, 2'b01, 16'h0001);
        // R10 nonexistent memory
        nxm_pulse = 1'b1; step(); nxm_pulse = 1'b0;
        step();
        rdchk(2'd2, 16'hC080, "R10 nxm flag and error");
        done(1'b1, 1'b1);
        rdchk(2'd0, 16'h0102, "R10 transfers blocked");
        wr(2'd2, 2'b10, 16'h4000);
        rdchk(2'd2, 16'hC080, "R10 write one ignored");
        wr(2'd2, 2'b10, 16'h0000);
        rdchk(2'd2, 16'h0080, "R10 write zero clears");
        done(1'b1, 1'b1);
        rdchk(2'd0, 16'h0103, "R10 transfers resume");
        // R12 output buffer
        wr(2'd3, 2'b01, 16'h00A5);
        chk("R12 low lane", dev_dout, 16'h00A5);
        wr(2'd3, 2'b10, 16'h5A00);
        chk("R12 high lane", dev_dout, 16'h5AA5);
        mem_rdata = 16'h1357; mem_load = 1'b1;
        wr(2'd3, 2'b11, 16'hFFFF);
        mem_load = 1'b0;
        chk("R12 memory load wins", dev_dout, 16'h1357);
        dev_din = 16'h2468; cyc_req = 1'b1; step(); cyc_req = 1'b0;
        rdchk(2'd3, 16'h2468, "R12 second capture");
        step();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule